// File: doc/BRIEF.md
# Compare/Capture Event Flags for a Timer Channel

This block keeps the event flags of one timer channel. The channel has up to four 16-bit general registers. Each register works either as an output compare register or as an input capture register. When its compare value equals the free-running counter, or when a capture strobe copies the counter into it, the register's event flag goes to 1. The counter comes from outside the block. The block stores the general register values, the flags and their interrupt requests.

Software reaches the block over a small register bus. It can read and write the general registers, and it can read the status word. A flag is cleared only by a handshake: first a status read must return the flag as 1, and then software writes 0 to that flag bit. A parameter removes registers C and D. When they are removed, their flag bits always read 0 and their registers cannot be written.

Top module: `ccflag_unit`

## Requirements
- R1: After reset every flag is 0, every interrupt request is 0, and every present general register holds all ones.
- R2: A register in compare mode (its `cap_mode_i` bit is 0) sets its flag at the clock edge where `cnt_i` equals the stored value.
- R3: A register in capture mode (its `cap_mode_i` bit is 1) takes `cnt_i` on a one-cycle `cap_stb_i` pulse. Its stored value and its flag both update at that same edge.
- R4: A flag clears only when a status write puts 0 in its bit after an earlier status read returned that bit as 1. A write of 0 without that earlier read leaves the flag at 1.
- R5: Writing 1 to a status bit never changes the flag. It does not set a clear flag, and it does not clear a set flag.
- R6: One read permits one clear. When the flag sets again after a clear, a new status read is needed before a write of 0 clears it.
- R7: When a set event and a permitted clear fall in the same cycle, the flag stays at 1.
- R8: `irq_o[i]` is 1 exactly while flag i is 1 and `irq_en_i[i]` is 1. It drops in the cycle after the flag clears.
- R9: With `HAS_CD` = 0, flag bits 2 and 3 always read 0, capture strobes and status writes do not affect them, and registers C and D read 0 and ignore writes.
- R10: Bus address map. Addresses 0 to 3 hold general registers A to D. Address 4 is the status word, where bit i is the flag of register i and the upper bits read 0. A register write appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Free-running counter value |
| cap_mode_i | input | 4 | Mode per register: 1 = capture, 0 = compare |
| cap_stb_i | input | 4 | One-cycle capture strobe per register |
| irq_en_i | input | 4 | Interrupt enable per flag |
| bus_addr_i | input | 3 | Register bus address |
| bus_rd_i | input | 1 | Read strobe. A read of the status word arms the flag handshake |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data for `bus_addr_i`, combinational |
| greg_o | output | 4 x CNT_W | Stored general register values |
| flags_o | output | 4 | Event flags |
| irq_o | output | 4 | Interrupt requests |

## Verification
The bench builds two copies of the block that share all inputs. One copy uses `HAS_CD` = 1 and the other uses `HAS_CD` = 0, both with a 16-bit counter. The full copy exercises compare, capture, the read-then-clear handshake and the set-beats-clear collision on live flags. The reduced copy receives the same strobes and writes on C and D, so the bench can show at its ports that those bits and registers stay at zero.

// File: rtl/ccflag_pkg.sv
package ccflag_pkg;
    localparam int NUM_GREG  = 4;
    localparam int ADDR_W    = 3;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 3'd4;

    typedef struct packed {
        logic flag;
        logic armed;
    } flag_st_t;
endpackage

// File: rtl/ccflag_greg.sv
module ccflag_greg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_i,
    input  logic         cap_mode_i,
    input  logic         cap_stb_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] val_o,
    output logic         evt_o
);
    typedef struct packed {
        logic [W-1:0] val;
    } greg_st_t;

    greg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i)
            st_d.val = wdata_i;
        // capture has priority over a software write in the same cycle
        if (cap_mode_i && cap_stb_i)
            st_d.val = cnt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{val: '1};
        else
            st_q <= st_d;
    end

    assign val_o = st_q.val;
    assign evt_o = cap_mode_i ? cap_stb_i : (cnt_i == st_q.val);

    AST_CAPTURE_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode_i && cap_stb_i) |=> (val_o == $past(cnt_i)));  // R3
endmodule

// File: rtl/ccflag_cell.sv
module ccflag_cell
    import ccflag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt_i,
    input  logic rd_stb_i,
    input  logic clr_req_i,
    output logic flag_o
);
    flag_st_t st_d, st_q;
    logic     clr_ok;

    always_comb begin
        st_d   = st_q;
        clr_ok = clr_req_i && st_q.armed;
        // a status read arms on 1 and disarms on 0
        if (rd_stb_i)
            st_d.armed = st_q.flag;
        if (clr_ok) begin
            st_d.flag  = 1'b0;
            st_d.armed = 1'b0;
        end
        if (set_evt_i)
            st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{flag: 1'b0, armed: 1'b0};
        else
            st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    AST_RISE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(set_evt_i));  // R5
    AST_FALL_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> $past(clr_req_i && st_q.armed));  // R4
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt_i |=> flag_o);  // R7
    AST_ARM_ONLY_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.armed) |-> $past(rd_stb_i && flag_o));  // R6
endmodule

// File: rtl/ccflag_unit.sv
module ccflag_unit
    import ccflag_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter bit HAS_CD = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [CNT_W-1:0]              cnt_i,
    input  logic [NUM_GREG-1:0]           cap_mode_i,
    input  logic [NUM_GREG-1:0]           cap_stb_i,
    input  logic [NUM_GREG-1:0]           irq_en_i,
    input  logic [ADDR_W-1:0]             bus_addr_i,
    input  logic                          bus_rd_i,
    input  logic                          bus_wr_i,
    input  logic [CNT_W-1:0]              bus_wdata_i,
    output logic [CNT_W-1:0]              bus_rdata_o,
    output logic [NUM_GREG-1:0][CNT_W-1:0] greg_o,
    output logic [NUM_GREG-1:0]           flags_o,
    output logic [NUM_GREG-1:0]           irq_o
);
    localparam int NUM_LIVE = HAS_CD ? NUM_GREG : 2;

    logic stat_rd, stat_wr;

    assign stat_rd = bus_rd_i && (bus_addr_i == STAT_ADDR);
    assign stat_wr = bus_wr_i && (bus_addr_i == STAT_ADDR);

    for (genvar i = 0; i < NUM_GREG; i++) begin : g_reg
        if (i < NUM_LIVE) begin : g_live
            logic evt;

            ccflag_greg #(.W(CNT_W)) u_greg (
                .clk        (clk),
                .rst_n      (rst_n),
                .cnt_i      (cnt_i),
                .cap_mode_i (cap_mode_i[i]),
                .cap_stb_i  (cap_stb_i[i]),
                .wr_i       (bus_wr_i && (bus_addr_i == ADDR_W'(i))),
                .wdata_i    (bus_wdata_i),
                .val_o      (greg_o[i]),
                .evt_o      (evt)
            );

            ccflag_cell u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .set_evt_i (evt),
                .rd_stb_i  (stat_rd),
                .clr_req_i (stat_wr && !bus_wdata_i[i]),
                .flag_o    (flags_o[i])
            );
        end else begin : g_rsvd
            assign greg_o[i]  = '0;
            assign flags_o[i] = 1'b0;
        end
    end

    assign irq_o = flags_o & irq_en_i;

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == STAT_ADDR)
            bus_rdata_o[NUM_GREG-1:0] = flags_o;
        else if (bus_addr_i < ADDR_W'(NUM_GREG))
            bus_rdata_o = greg_o[bus_addr_i[1:0]];
    end
endmodule

// File: tb/ccflag_unit_bench.sv
module ccflag_unit_bench;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  cnt = '0;
    logic [3:0]    mode = '0, stb = '0, en = '0;
    logic [2:0]    addr = '0;
    logic          rd = 1'b0, wr = 1'b0;
    logic [W-1:0]  wdata = '0;
    logic [W-1:0]  rdata_f, rdata_r;
    logic [3:0][W-1:0] greg_f, greg_r;
    logic [3:0]    flags_f, flags_r, irq_f, irq_r;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ccflag_unit #(.CNT_W(W), .HAS_CD(1'b1)) u_ccflag_unit (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cap_mode_i(mode),
        .cap_stb_i(stb), .irq_en_i(en), .bus_addr_i(addr), .bus_rd_i(rd),
        .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_f),
        .greg_o(greg_f), .flags_o(flags_f), .irq_o(irq_f));

    ccflag_unit #(.CNT_W(W), .HAS_CD(1'b0)) u_ccflag_unit_nocd (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cap_mode_i(mode),
        .cap_stb_i(stb), .irq_en_i(en), .bus_addr_i(addr), .bus_rd_i(rd),
        .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_r),
        .greg_o(greg_r), .flags_o(flags_r), .irq_o(irq_r));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [W-1:0] df, output logic [W-1:0] dr);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1;
        df = rdata_f; dr = rdata_r;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic t_reset();
        logic [W-1:0] f, r;
        chk("R1 flags", {28'd0, flags_f}, 32'h0);
        chk("R1 irq", {28'd0, irq_f}, 32'h0);
        bus_read(3'd0, f, r);
        chk("R1 greg A reset", {16'd0, f}, 32'hFFFF);
        bus_read(3'd2, f, r);
        chk("R9 reserved greg C reads 0", {16'd0, r}, 32'h0);
    endtask

    task automatic t_compare();
        logic [W-1:0] f, r;
        bus_write(3'd0, 16'h0010);
        bus_read(3'd0, f, r);
        chk("R10 greg A write/readback", {16'd0, f}, 32'h0010);
        en = 4'b0001;
        @(negedge clk); cnt = 16'h000F;
        @(negedge clk);
        chk("R2 no match yet", {31'd0, flags_f[0]}, 32'h0);
        cnt = 16'h0010;
        @(negedge clk);
        chk("R2 compare sets flag A", {31'd0, flags_f[0]}, 32'h1);
        chk("R8 irq A asserted", {28'd0, irq_f}, 32'h1);
        cnt = 16'h0000;
    endtask

    task automatic t_clear_rules();
        logic [W-1:0] f, r;
        bus_write(3'd4, 16'h0000);
        chk("R4 unarmed write 0 keeps flag", {31'd0, flags_f[0]}, 32'h1);
        bus_write(3'd4, 16'hFFFF);
        chk("R5 write 1 keeps set flag", {31'd0, flags_f[0]}, 32'h1);
        chk("R5 write 1 does not set B", {31'd0, flags_f[1]}, 32'h0);
        bus_read(3'd4, f, r);
        chk("R10 status read bit0", {16'd0, f}, 32'h0001);
        bus_write(3'd4, 16'h0000);
        chk("R4 armed write 0 clears", {31'd0, flags_f[0]}, 32'h0);
        chk("R8 irq drops after clear", {28'd0, irq_f}, 32'h0);
    endtask

    task automatic t_one_shot();
        logic [W-1:0] f, r;
        @(negedge clk); cnt = 16'h0010;
        @(negedge clk); cnt = 16'h0000;
        chk("R6 flag set again", {31'd0, flags_f[0]}, 32'h1);
        bus_write(3'd4, 16'h0000);
        chk("R6 old arm consumed", {31'd0, flags_f[0]}, 32'h1);
        bus_read(3'd4, f, r);
        bus_write(3'd4, 16'h0000);
        chk("R6 new read allows clear", {31'd0, flags_f[0]}, 32'h0);
    endtask

    task automatic t_capture();
        logic [W-1:0] f, r;
        mode = 4'b0010;
        @(negedge clk); cnt = 16'h1234; stb = 4'b0010;
        @(negedge clk); stb = 4'b0000;
        chk("R3 capture sets flag B", {31'd0, flags_f[1]}, 32'h1);
        chk("R3 capture stores count", {16'd0, greg_f[1]}, 32'h1234);
        bus_read(3'd4, f, r);
        @(negedge clk);
        addr = 3'd4; wdata = 16'h0000; wr = 1'b1; cnt = 16'h2222; stb = 4'b0010;
        @(negedge clk);
        wr = 1'b0; stb = 4'b0000;
        chk("R7 set beats clear", {31'd0, flags_f[1]}, 32'h1);
        chk("R3 recapture value", {16'd0, greg_f[1]}, 32'h2222);
        bus_read(3'd4, f, r);
        bus_write(3'd4, 16'h0000);
        chk("R4 B cleared", {31'd0, flags_f[1]}, 32'h0);
    endtask

    task automatic t_reserved();
        logic [W-1:0] f, r;
        mode = 4'b1100; cnt = 16'h0555;
        @(negedge clk); stb = 4'b1100;
        @(negedge clk); stb = 4'b0000;
        chk("R3 full unit C,D captured", {28'd0, flags_f}, 32'hC);
        chk("R9 reduced unit C,D stay 0", {28'd0, flags_r}, 32'h0);
        bus_read(3'd4, f, r);
        chk("R9 reduced status reads 0", {16'd0, r}, 32'h0);
        bus_write(3'd2, 16'hABCD);
        bus_read(3'd2, f, r);
        chk("R9 reduced greg C ignores write", {16'd0, r}, 32'h0);
        chk("R10 full greg C write", {16'd0, f}, 32'hABCD);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_compare();
        t_clear_rules();
        t_one_shot();
        t_capture();
        t_reserved();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule